// File: doc/BRIEF.md
# Store Queue with Load Bypass

This block sits between a processor's load/store port and a single memory request port. Stores are placed into a small in-order queue and accepted at once, so the processor never waits for a store to reach memory. Loads take precedence on the memory port. A load can therefore reach memory ahead of stores that are still queued, and it returns whatever memory holds at that moment. No data is taken from the queue.

Ordering is weak by default. When software needs a write to land before a dependent read, it raises a barrier request. The barrier completes only once every queued store has been acknowledged by memory. The memory port carries one transaction at a time and tolerates any response latency.

Top module: `store_queue_bypass`

## Requirements
- R1: While the queue holds fewer than DEPTH (default 4) stores, a store request (`cpu_we`=1) sees `cpu_ready`=1 in the same cycle, whatever the memory is doing.
- R2: With DEPTH stores queued, `cpu_ready` is 0 for stores, but it stays 1 for a load request when no load is in progress.
- R3: Queued stores are written to memory in arrival order. Each store produces exactly one write carrying its own address and data.
- R4: If a load is waiting when the memory port becomes idle, the next memory request is a read (`mem_we`=0), even when stores are queued.
- R5: A load reads memory as it stands when the read is performed. Queued stores to the same address are not forwarded. `cpu_rvalid` pulses for one cycle, in the cycle after the read's `mem_ack`, and `cpu_rdata` carries that `mem_rdata`.
- R6: Once `mem_req` is raised, it stays high with its address, direction and write data held steady until `mem_ack`. It is low in the cycle after `mem_ack`.
- R7: While `sync_req` is held, `sync_done` is 1 exactly in the cycles that follow a cycle in which the queue was empty. It rises two clock edges after the edge that takes the final store's `mem_ack`, and it is never 1 while stores are queued.
- R8: Only one load is in progress at a time. From acceptance until its `cpu_rvalid`, `cpu_ready` is 0 for loads.
- R9: After reset, `mem_req`, `cpu_rvalid` and `sync_done` are 0, and `cpu_ready` is 1 for both stores and loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Request address |
| cpu_wdata | input | DW | Store data |
| cpu_ready | output | 1 | Request accepted when high together with cpu_valid |
| cpu_rvalid | output | 1 | One-cycle load data valid |
| cpu_rdata | output | DW | Load data |
| sync_req | input | 1 | Barrier request, held until sync_done |
| sync_done | output | 1 | Barrier complete: queue drained |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory direction, 1 = write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | One-cycle memory completion |
| mem_rdata | input | DW | Read data, valid with mem_ack |

## Verification
The hardest situation to reach from the ports is a load overtaking a queued store to the same address, because it only happens when a load arrives while another store occupies the memory port. The bench slows its memory model to twenty cycles per access and queues two stores, the second to an address preloaded with a known value. It then issues a load to that address while the first write is still outstanding. The load must come back holding the old value, with only one write performed so far. Filling the queue also needs a slow memory, so that four stores stay parked while the store-only stall is probed.

// File: rtl/sqb_pkg.sv
package sqb_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE = 2'd0,
    PORT_READ = 2'd1,
    PORT_WRITE = 2'd2
  } port_state_e;
endpackage

// File: rtl/sqb_store_fifo.sv
module sqb_store_fifo #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PW:0]      wr_ptr, rd_ptr;

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr[PW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign head_data = slots[rd_ptr[PW-1:0]];
  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[PW-1:0] == rd_ptr[PW-1:0]) && (wr_ptr[PW] != rd_ptr[PW]);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/sqb_port_ctrl.sv
module sqb_port_ctrl
  import sqb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_accept,
  input  logic [AW-1:0] ld_addr_in,
  output logic          ld_busy,
  input  logic          q_empty,
  input  logic [AW-1:0] q_head_addr,
  input  logic [DW-1:0] q_head_data,
  output logic          q_pop,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata
);
  port_state_e   st;
  logic          ld_pend;
  logic [AW-1:0] ld_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PORT_IDLE;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
      ld_pend    <= 1'b0;
      ld_addr    <= '0;
    end else begin
      cpu_rvalid <= 1'b0;
      if (ld_accept) begin
        ld_pend <= 1'b1;
        ld_addr <= ld_addr_in;
      end
      unique case (st)
        PORT_IDLE: begin
          // a waiting load wins over the queue head
          if (ld_pend) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ld_addr;
            st       <= PORT_READ;
          end else if (!q_empty) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= q_head_addr;
            mem_wdata <= q_head_data;
            st        <= PORT_WRITE;
          end
        end
        PORT_READ: begin
          if (mem_ack) begin
            mem_req    <= 1'b0;
            cpu_rvalid <= 1'b1;
            cpu_rdata  <= mem_rdata;
            ld_pend    <= 1'b0;
            st         <= PORT_IDLE;
          end
        end
        PORT_WRITE: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            st      <= PORT_IDLE;
          end
        end
        default: st <= PORT_IDLE;
      endcase
    end
  end

  assign q_pop   = (st == PORT_WRITE) && mem_ack;
  assign ld_busy = ld_pend;

  a_r6_hold_request: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  a_r6_release_after_ack: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req);
  a_r4_load_first: assert property (@(posedge clk) disable iff (rst)
    !mem_req && ld_pend |=> mem_req && !mem_we);
  a_r5_return_data: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack && !mem_we |=> cpu_rvalid && (cpu_rdata == $past(mem_rdata)));
  a_r8_single_load: assert property (@(posedge clk) disable iff (rst)
    ld_accept |-> !ld_pend);
endmodule

// File: rtl/store_queue_bypass.sv
module store_queue_bypass #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_valid,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata,
  input  logic          sync_req,
  output logic          sync_done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int EW = AW + DW;

  logic          q_full, q_empty, q_pop, q_push;
  logic [EW-1:0] q_head;
  logic          ld_busy, ld_accept;

  assign cpu_ready = cpu_we ? !q_full : !ld_busy;
  assign q_push    = cpu_valid && cpu_ready && cpu_we;
  assign ld_accept = cpu_valid && cpu_ready && !cpu_we;

  sqb_store_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (q_push),
    .push_data ({cpu_addr, cpu_wdata}),
    .pop       (q_pop),
    .head_data (q_head),
    .full      (q_full),
    .empty     (q_empty)
  );

  sqb_port_ctrl #(.AW(AW), .DW(DW)) u_port (
    .clk         (clk),
    .rst         (rst),
    .ld_accept   (ld_accept),
    .ld_addr_in  (cpu_addr),
    .ld_busy     (ld_busy),
    .q_empty     (q_empty),
    .q_head_addr (q_head[EW-1:DW]),
    .q_head_data (q_head[DW-1:0]),
    .q_pop       (q_pop),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .cpu_rvalid  (cpu_rvalid),
    .cpu_rdata   (cpu_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) sync_done <= 1'b0;
    else     sync_done <= sync_req && q_empty;
  end

  a_r7_done_only_drained: assert property (@(posedge clk) disable iff (rst)
    sync_done |-> $past(q_empty));
  a_r7_no_done_with_write: assert property (@(posedge clk) disable iff (rst)
    sync_done |-> !(mem_req && mem_we));
endmodule

// File: tb/store_queue_bypass_tb.sv
module store_queue_bypass_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NV = 6;
  // each entry: {address, data} of one store
  localparam logic [23:0] VEC [NV] = '{
    24'h02_1111, 24'h07_2222, 24'h03_3333,
    24'h0C_4444, 24'h09_5555, 24'h0E_6666
  };

  logic clk = 1'b0;
  logic rst;
  logic cpu_valid, cpu_we, cpu_ready, cpu_rvalid;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic sync_req, sync_done;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int lat = 2;
  int lat_cnt = 0;
  int wcnt = 0;
  int last_wack = -10;
  int r6_bad = 0;
  bit finished = 0;
  logic [DW-1:0] mem [16];
  logic [AW-1:0] wlog_addr [64];
  logic [DW-1:0] wlog_data [64];
  logic [DW-1:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  store_queue_bypass #(.AW(AW), .DW(DW), .DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .sync_req(sync_req),
    .sync_done(sync_done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // memory model with adjustable latency
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'hA000 + 16'(i);
  end
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) begin
      lat_cnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (lat_cnt >= lat) begin
        lat_cnt <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[3:0]] <= mem_wdata;
          wlog_addr[wcnt] <= mem_addr;
          wlog_data[wcnt] <= mem_wdata;
          wcnt <= wcnt + 1;
        end else begin
          mem_rdata <= mem[mem_addr[3:0]];
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  // request stability monitor (R6) and write-ack timing record (R7)
  logic p_req, p_ack, p_we;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wdata;
  initial begin
    p_req = 0; p_ack = 0; p_we = 0; p_addr = '0; p_wdata = '0;
  end
  always @(negedge clk) begin
    if (!rst) begin
      if (p_req && !p_ack && (!mem_req || mem_addr != p_addr || mem_we != p_we ||
          (p_we && mem_wdata != p_wdata)))
        r6_bad = r6_bad + 1;
      if (p_req && p_ack && mem_req) r6_bad = r6_bad + 1;
      if (mem_ack && mem_we) last_wack = cyc;
    end
    p_req = mem_req; p_ack = mem_ack; p_we = mem_we; p_addr = mem_addr; p_wdata = mem_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at a negedge
  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cpu_valid = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    cpu_valid = 0;
  endtask

  task automatic issue_load(input logic [AW-1:0] a);
    cpu_valid = 1; cpu_we = 0; cpu_addr = a;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    cpu_valid = 0;
  endtask

  task automatic wait_load(output logic [DW-1:0] d);
    while (!cpu_rvalid) @(negedge clk);
    d = cpu_rdata;
  endtask

  task automatic do_sync(input bit timed);
    sync_req = 1;
    @(negedge clk);
    if (timed) check(sync_done == 0, "R7 done early", int'(sync_done), 0);
    while (!sync_done) @(negedge clk);
    if (timed) check(cyc == last_wack + 2, "R7 done timing", cyc, last_wack + 2);
    sync_req = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; cpu_valid = 0; cpu_we = 1; cpu_addr = '0; cpu_wdata = '0; sync_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R9 reset state
    check(mem_req == 0, "R9 mem_req", int'(mem_req), 0);
    check(cpu_rvalid == 0, "R9 cpu_rvalid", int'(cpu_rvalid), 0);
    check(sync_done == 0, "R9 sync_done", int'(sync_done), 0);
    check(cpu_ready == 1, "R9 ready store", int'(cpu_ready), 1);
    cpu_we = 0; #1;
    check(cpu_ready == 1, "R9 ready load", int'(cpu_ready), 1);
    @(negedge clk);

    // table walk: back-to-back stores, R1 while the queue has room
    lat = 2;
    for (int i = 0; i < NV; i++) begin
      cpu_valid = 1; cpu_we = 1; cpu_addr = VEC[i][23:16]; cpu_wdata = VEC[i][15:0]; #1;
      if (i < 4) check(cpu_ready == 1, "R1 store ready", int'(cpu_ready), 1);
      do_store(VEC[i][23:16], VEC[i][15:0]);
    end
    do_sync(1);
    // R3 write order and content
    check(wcnt == NV, "R3 write count", wcnt, NV);
    for (int i = 0; i < NV; i++)
      check({wlog_addr[i], wlog_data[i]} == VEC[i], "R3 write order",
            int'({wlog_addr[i], wlog_data[i]}), int'(VEC[i]));
    // R5 read back after barrier
    issue_load(VEC[3][23:16]);
    wait_load(got);
    check(got == VEC[3][15:0], "R5 readback", int'(got), int'(VEC[3][15:0]));
    @(negedge clk);

    // weak ordering: load overtakes queued store to the same address (R4, R5)
    lat = 20;
    do_store(8'h01, 16'hBEEF);
    do_store(8'h05, 16'hCAFE);
    issue_load(8'h05);
    cpu_we = 0; #1;
    check(cpu_ready == 0, "R8 load busy", int'(cpu_ready), 0);
    wait_load(got);
    check(got == 16'hA005, "R5 no forwarding", int'(got), 16'hA005);
    check(wcnt == NV + 1, "R4 load before second store", wcnt, NV + 1);
    @(negedge clk);
    do_sync(1);
    check(mem[5] == 16'hCAFE, "R3 store landed", int'(mem[5]), 16'hCAFE);

    // fill the queue with a slow memory (R2)
    lat = 40;
    for (int i = 0; i < 4; i++) do_store(8'(8'h20 + i), 16'(16'h7000 + i));
    cpu_we = 1; #1;
    check(cpu_ready == 0, "R2 full blocks store", int'(cpu_ready), 0);
    cpu_we = 0; #1;
    check(cpu_ready == 1, "R2 load accepted when full", int'(cpu_ready), 1);
    issue_load(8'h02);
    wait_load(got);
    check(got == VEC[0][15:0], "R5 load while full", int'(got), int'(VEC[0][15:0]));
    @(negedge clk);
    lat = 1;
    do_sync(1);
    check(wlog_data[wcnt-1] == 16'h7003, "R3 last of fill", int'(wlog_data[wcnt-1]), 16'h7003);
    check(r6_bad == 0, "R6 request held", r6_bad, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule